// File: doc/BRIEF.md
# Post-Update Load Unit

This block runs a family of loads that read memory at the unmodified base register and then move that base forward by an offset. Each instruction arrives as decoded fields: access size, an extension-mode flag, an addressing form, the destination and base register numbers, a 16-bit displacement field, and the current values of the base and index registers. The unit issues one single-beat read, shapes the returned data, and then produces two register write-backs in the same cycle. One carries the loaded value to the destination register. The other carries the advanced address back to the base register.

Some combinations of fields are illegal. These include a base register number of zero, a base equal to the destination, and size, form or extension pairings that the instruction family does not define. For any of these the unit skips the memory access. It then raises an invalid flag for one cycle, with neither write-back enabled. The unit handles one instruction at a time and accepts the next only when idle.

Field encodings: size 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. Form 0 = signed displacement, 1 = scaled doubleword displacement, 2 = index register, 3 = reserved. A sign-extension flag of 1 selects algebraic mode. Read data comes back right-justified on a 64-bit bus. Any bits above the requested size are ignored.

Top module: `postupd_load_unit`

## Requirements
- R1: The read request carries the base register value captured at issue, unmodified, as its address and the size code as its size. Both stay stable while the request waits for acceptance.
- R2: In form 0 the base write-back value is the base plus the 16-bit displacement sign-extended to 64 bits.
- R3: In form 1 the base write-back value is the base plus the low 14 bits of the displacement field with two zero bits appended, sign-extended to 64 bits.
- R4: In form 2 the base write-back value is the base plus the index register value, with 64-bit wrap-around and no overflow indication.
- R5: With the sign-extension flag at 0, byte, halfword and word loads write the low 8, 16 or 32 bits of the read data and clear every higher bit, regardless of what the upper bus bits carry.
- R6: With the sign-extension flag at 1, halfword loads in forms 0 and 2 and word loads in form 2 fill every bit above the item with the item's most significant bit.
- R7: Doubleword loads write all 64 read bits unchanged. The sign-extension flag has no effect on them.
- R8: A base register number of 0, or a base equal to the destination, produces a one-cycle done pulse with the invalid flag set. No read request is issued and neither write enable is raised.
- R9: These combinations are invalid and handled as in R8: sign-extended byte in any form, sign-extended word in form 0, form 1 with a size other than doubleword, form 0 with doubleword size, and form 3.
- R10: The issue-ready output is high only when the unit is idle. A valid instruction ends with a single-cycle done pulse that carries both write enables together, and the unit is ready again in the following cycle.
- R11: The destination write-back address equals the destination register number, and the base write-back address equals the base register number, both captured at issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Instruction present |
| issue_ready_o | output | 1 | Unit idle, instruction accepted this cycle |
| size_i | input | 2 | Access size code |
| sext_i | input | 1 | Algebraic (sign-extending) mode |
| form_i | input | 2 | Addressing form code |
| rt_i | input | 5 | Destination register number |
| ra_i | input | 5 | Base register number |
| disp_i | input | 16 | Displacement field |
| ra_val_i | input | 64 | Base register value |
| rb_val_i | input | 64 | Index register value |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_addr_o | output | 64 | Read address |
| mem_size_o | output | 2 | Read size code |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read data, right-justified |
| done_o | output | 1 | Instruction completion pulse |
| invalid_o | output | 1 | Instruction form rejected |
| rt_we_o | output | 1 | Destination write enable |
| rt_addr_o | output | 5 | Destination register number |
| rt_data_o | output | 64 | Loaded value |
| ra_we_o | output | 1 | Base write enable |
| ra_addr_o | output | 5 | Base register number |
| ra_data_o | output | 64 | Advanced base value |

## Verification
On every cycle the assertions check the protocol shape. Write enables appear only inside a done pulse and always as a pair. Done lasts one cycle. Issue-ready is low while a request or a completion is pending. A waiting request holds its address and size. A rejected form never writes, and no write targets register 0 or a base equal to the destination. The values themselves can only be shown by the bench's scenarios. These cover the three offset calculations including wrap-around, zero versus sign fill for each size with both signs of the item, and the masking of upper bus bits. They also cover the full list of illegal combinations, and the absence of read requests for rejected instructions.

// File: rtl/pul_pkg.sv
package pul_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } ld_size_e;

  typedef enum logic [1:0] {
    FM_DISP = 2'd0,
    FM_DSCL = 2'd1,
    FM_INDX = 2'd2,
    FM_RSVD = 2'd3
  } ld_form_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } ctrl_st_e;
endpackage

// File: rtl/pul_decode.sv
module pul_decode
  import pul_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int AW     = 5,
  parameter int DISP_W = 16
) (
  input  logic [1:0]        size_i,
  input  logic              sext_i,
  input  logic [1:0]        form_i,
  input  logic [AW-1:0]     rt_i,
  input  logic [AW-1:0]     ra_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   rb_val_i,
  output logic              invalid_o,
  output logic [XLEN-1:0]   offset_o
);
  localparam int DSF_W = DISP_W - 2;

  ld_size_e sz;
  ld_form_e fm;
  logic     reg_bad;
  logic     combo_bad;
  logic [DISP_W-1:0] dscl;

  assign sz   = ld_size_e'(size_i);
  assign fm   = ld_form_e'(form_i);
  assign dscl = {disp_i[DSF_W-1:0], 2'b00};

  assign reg_bad = (ra_i == '0) || (ra_i == rt_i);

  always_comb begin
    combo_bad = 1'b0;
    unique case (fm)
      FM_DISP: combo_bad = (sz == SZ_DBL) ||
                           (sext_i && ((sz == SZ_BYTE) || (sz == SZ_WORD)));
      FM_DSCL: combo_bad = (sz != SZ_DBL);
      FM_INDX: combo_bad = sext_i && (sz == SZ_BYTE);
      default: combo_bad = 1'b1;
    endcase
  end

  assign invalid_o = reg_bad || combo_bad;

  always_comb begin
    unique case (fm)
      FM_DISP: offset_o = {{(XLEN-DISP_W){disp_i[DISP_W-1]}}, disp_i};
      FM_DSCL: offset_o = {{(XLEN-DISP_W){dscl[DISP_W-1]}}, dscl};
      FM_INDX: offset_o = rb_val_i;
      default: offset_o = '0;
    endcase
  end
endmodule

// File: rtl/pul_extend.sv
module pul_extend
  import pul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]      size_i,
  input  logic            sext_i,
  input  logic [XLEN-1:0] raw_i,
  output logic [XLEN-1:0] value_o
);
  localparam int NSUB = 3;

  logic [XLEN-1:0] lane [NSUB];

  for (genvar k = 0; k < NSUB; k++) begin : g_lane
    localparam int W = 8 << k;
    assign lane[k] = {{(XLEN-W){sext_i & raw_i[W-1]}}, raw_i[W-1:0]};
  end

  always_comb begin
    unique case (ld_size_e'(size_i))
      SZ_BYTE: value_o = lane[0];
      SZ_HALF: value_o = lane[1];
      SZ_WORD: value_o = lane[2];
      default: value_o = raw_i;
    endcase
  end
endmodule

// File: rtl/pul_ctrl.sv
module pul_ctrl
  import pul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_valid_i,
  output logic            issue_ready_o,
  input  logic            invalid_i,
  input  logic [1:0]      size_i,
  input  logic            sext_i,
  input  logic [AW-1:0]   rt_i,
  input  logic [AW-1:0]   ra_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] upd_i,
  output logic [1:0]      size_q_o,
  output logic            sext_q_o,
  output logic            mem_req_valid_o,
  input  logic            mem_req_ready_i,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [1:0]      mem_size_o,
  input  logic            mem_rsp_valid_i,
  input  logic [XLEN-1:0] ext_data_i,
  output logic            done_o,
  output logic            invalid_o,
  output logic            rt_we_o,
  output logic [AW-1:0]   rt_addr_o,
  output logic [XLEN-1:0] rt_data_o,
  output logic            ra_we_o,
  output logic [AW-1:0]   ra_addr_o,
  output logic [XLEN-1:0] ra_data_o
);
  ctrl_st_e        st_q, st_d;
  logic [1:0]      size_q;
  logic            sext_q;
  logic            inv_q;
  logic [AW-1:0]   rt_q, ra_q;
  logic [XLEN-1:0] addr_q, upd_q, data_q;
  logic            accept;

  assign issue_ready_o = (st_q == ST_IDLE);
  assign accept        = issue_ready_o && issue_valid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (issue_valid_i) st_d = invalid_i ? ST_DONE : ST_REQ;
      ST_REQ:  if (mem_req_ready_i) st_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid_i) st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      size_q <= '0;
      sext_q <= 1'b0;
      inv_q  <= 1'b0;
      rt_q   <= '0;
      ra_q   <= '0;
      addr_q <= '0;
      upd_q  <= '0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        size_q <= size_i;
        sext_q <= sext_i;
        inv_q  <= invalid_i;
        rt_q   <= rt_i;
        ra_q   <= ra_i;
        addr_q <= addr_i;
        upd_q  <= upd_i;
      end
      if ((st_q == ST_WAIT) && mem_rsp_valid_i) data_q <= ext_data_i;
    end
  end

  assign size_q_o        = size_q;
  assign sext_q_o        = sext_q;
  assign mem_req_valid_o = (st_q == ST_REQ);
  assign mem_addr_o      = addr_q;
  assign mem_size_o      = size_q;

  assign done_o    = (st_q == ST_DONE);
  assign invalid_o = done_o && inv_q;
  assign rt_we_o   = done_o && !inv_q;
  assign ra_we_o   = done_o && !inv_q;
  assign rt_addr_o = rt_q;
  assign ra_addr_o = ra_q;
  assign rt_data_o = data_q;
  assign ra_data_o = upd_q;
endmodule

// File: rtl/postupd_load_unit.sv
module postupd_load_unit #(
  parameter int XLEN   = 64,
  parameter int AW     = 5,
  parameter int DISP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  output logic              issue_ready_o,
  input  logic [1:0]        size_i,
  input  logic              sext_i,
  input  logic [1:0]        form_i,
  input  logic [AW-1:0]     rt_i,
  input  logic [AW-1:0]     ra_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [XLEN-1:0]   rb_val_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [1:0]        mem_size_o,
  input  logic              mem_rsp_valid_i,
  input  logic [XLEN-1:0]   mem_rsp_data_i,
  output logic              done_o,
  output logic              invalid_o,
  output logic              rt_we_o,
  output logic [AW-1:0]     rt_addr_o,
  output logic [XLEN-1:0]   rt_data_o,
  output logic              ra_we_o,
  output logic [AW-1:0]     ra_addr_o,
  output logic [XLEN-1:0]   ra_data_o
);
  logic            dec_invalid;
  logic [XLEN-1:0] dec_offset;
  logic [XLEN-1:0] upd_addr;
  logic [1:0]      size_q;
  logic            sext_q;
  logic [XLEN-1:0] ext_data;

  pul_decode #(.XLEN(XLEN), .AW(AW), .DISP_W(DISP_W)) u_decode (
    .size_i    (size_i),
    .sext_i    (sext_i),
    .form_i    (form_i),
    .rt_i      (rt_i),
    .ra_i      (ra_i),
    .disp_i    (disp_i),
    .rb_val_i  (rb_val_i),
    .invalid_o (dec_invalid),
    .offset_o  (dec_offset)
  );

  // wrap-around: carry out discarded
  assign upd_addr = ra_val_i + dec_offset;

  pul_extend #(.XLEN(XLEN)) u_extend (
    .size_i  (size_q),
    .sext_i  (sext_q),
    .raw_i   (mem_rsp_data_i),
    .value_o (ext_data)
  );

  pul_ctrl #(.XLEN(XLEN), .AW(AW)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .issue_valid_i   (issue_valid_i),
    .issue_ready_o   (issue_ready_o),
    .invalid_i       (dec_invalid),
    .size_i          (size_i),
    .sext_i          (sext_i),
    .rt_i            (rt_i),
    .ra_i            (ra_i),
    .addr_i          (ra_val_i),
    .upd_i           (upd_addr),
    .size_q_o        (size_q),
    .sext_q_o        (sext_q),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_addr_o      (mem_addr_o),
    .mem_size_o      (mem_size_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .ext_data_i      (ext_data),
    .done_o          (done_o),
    .invalid_o       (invalid_o),
    .rt_we_o         (rt_we_o),
    .rt_addr_o       (rt_addr_o),
    .rt_data_o       (rt_data_o),
    .ra_we_o         (ra_we_o),
    .ra_addr_o       (ra_addr_o),
    .ra_data_o       (ra_data_o)
  );
endmodule

// File: rtl/postupd_load_unit_chk.sv
module postupd_load_unit_chk #(
  parameter int XLEN = 64,
  parameter int AW   = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            issue_ready_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [1:0]      mem_size_o,
  input logic            done_o,
  input logic            invalid_o,
  input logic            rt_we_o,
  input logic [AW-1:0]   rt_addr_o,
  input logic            ra_we_o,
  input logic [AW-1:0]   ra_addr_o
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_addr_o) && $stable(mem_size_o)); // R1

  AST_INV_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !rt_we_o && !ra_we_o); // R8

  AST_BAD_REGS_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_we_o |-> (ra_addr_o != '0) && (ra_addr_o != rt_addr_o)); // R8

  AST_WE_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_we_o || ra_we_o) |-> done_o); // R10

  AST_WE_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rt_we_o == ra_we_o) && (rt_we_o != invalid_o)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o || done_o) |-> !issue_ready_o); // R10
endmodule

bind postupd_load_unit postupd_load_unit_chk #(.XLEN(XLEN), .AW(AW)) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .issue_ready_o   (issue_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_addr_o      (mem_addr_o),
  .mem_size_o      (mem_size_o),
  .done_o          (done_o),
  .invalid_o       (invalid_o),
  .rt_we_o         (rt_we_o),
  .rt_addr_o       (rt_addr_o),
  .ra_we_o         (ra_we_o),
  .ra_addr_o       (ra_addr_o)
);

// File: tb/postupd_load_unit_tb_top.sv
module postupd_load_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_valid_i = 1'b0;
  logic        issue_ready_o;
  logic [1:0]  size_i = '0;
  logic        sext_i = 1'b0;
  logic [1:0]  form_i = '0;
  logic [4:0]  rt_i = '0;
  logic [4:0]  ra_i = '0;
  logic [15:0] disp_i = '0;
  logic [63:0] ra_val_i = '0;
  logic [63:0] rb_val_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [63:0] mem_addr_o;
  logic [1:0]  mem_size_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        done_o, invalid_o, rt_we_o, ra_we_o;
  logic [4:0]  rt_addr_o, ra_addr_o;
  logic [63:0] rt_data_o, ra_data_o;

  always #10 clk_i = ~clk_i; // 50 MHz

  postupd_load_unit dut_i (
    .clk_i, .rst_ni, .issue_valid_i, .issue_ready_o, .size_i, .sext_i, .form_i,
    .rt_i, .ra_i, .disp_i, .ra_val_i, .rb_val_i, .mem_req_valid_o,
    .mem_req_ready_i, .mem_addr_o, .mem_size_o, .mem_rsp_valid_i,
    .mem_rsp_data_i, .done_o, .invalid_o, .rt_we_o, .rt_addr_o, .rt_data_o,
    .ra_we_o, .ra_addr_o, .ra_data_o
  );

  typedef struct {
    string       tag;
    logic        inv;
    logic [4:0]  rt;
    logic [4:0]  ra;
    logic [63:0] rt_val;
    logic [63:0] ra_val;
    logic [63:0] addr;
    logic [1:0]  size;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  int          exp_reqs = 0;
  int          seen_reqs = 0;
  logic [63:0] last_addr = '0;
  logic [1:0]  last_size = '0;
  bit          finished = 0;

  // low 32 bits echo the address so sign bits are controllable; upper bits are noise
  function automatic logic [63:0] mem_word(input logic [63:0] a);
    logic [63:0] h;
    h = (a ^ 64'hA5C3_96E1_0F87_2D4B) * 64'h9E37_79B9_7F4A_7C15;
    return {h[63:32], a[31:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input string tag, input logic [1:0] sz, input logic sx,
                       input logic [1:0] fm, input logic [4:0] rt, input logic [4:0] ra,
                       input logic [15:0] d, input logic [63:0] rav, input logic [63:0] rbv);
    exp_t        e;
    logic [63:0] off, w;
    logic        bad;
    bad = (ra == 5'd0) || (ra == rt) || (fm == 2'd3) ||
          (sx && sz == 2'd0) || (sx && sz == 2'd2 && fm == 2'd0) ||
          (fm == 2'd1 && sz != 2'd3) || (fm == 2'd0 && sz == 2'd3);
    case (fm)
      2'd0:    off = {{48{d[15]}}, d};
      2'd1:    off = {{48{d[13]}}, d[13:0], 2'b00};
      default: off = rbv;
    endcase
    w = mem_word(rav);
    case (sz)
      2'd0:    e.rt_val = {56'd0, w[7:0]};
      2'd1:    e.rt_val = {{48{sx & w[15]}}, w[15:0]};
      2'd2:    e.rt_val = {{32{sx & w[31]}}, w[31:0]};
      default: e.rt_val = w;
    endcase
    e.tag = tag; e.inv = bad; e.rt = rt; e.ra = ra;
    e.ra_val = rav + off; e.addr = rav; e.size = sz;
    sb.push_back(e);
    if (!bad) exp_reqs++;
    @(negedge clk_i);
    while (!issue_ready_o) @(negedge clk_i);
    issue_valid_i = 1'b1; size_i = sz; sext_i = sx; form_i = fm;
    rt_i = rt; ra_i = ra; disp_i = d; ra_val_i = rav; rb_val_i = rbv;
    @(negedge clk_i);
    issue_valid_i = 1'b0;
    check({"R10 busy after issue ", tag}, {63'd0, issue_ready_o}, 64'd0);
  endtask

  // memory model
  initial begin
    int stall = 0, delay = 0, cnt = 0;
    forever begin
      @(negedge clk_i);
      mem_rsp_valid_i = 1'b0;
      if (mem_req_ready_i) begin
        mem_req_ready_i = 1'b0;
        repeat (delay) @(negedge clk_i);
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = mem_word(last_addr);
        cnt++; stall = cnt % 3; delay = (cnt / 2) % 3;
      end else if (mem_req_valid_o) begin
        if (stall == 0) begin
          mem_req_ready_i = 1'b1;
          last_addr = mem_addr_o;
          last_size = mem_size_o;
          seen_reqs++;
        end else stall--;
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && done_o) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10: actual unexpected done expected none");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({"R8 R9 invalid ", e.tag}, {63'd0, invalid_o}, {63'd0, e.inv});
          check({"R8 R10 rt_we ", e.tag}, {63'd0, rt_we_o}, {63'd0, !e.inv});
          check({"R8 R10 ra_we ", e.tag}, {63'd0, ra_we_o}, {63'd0, !e.inv});
          if (!e.inv) begin
            check({"R11 rt addr ", e.tag}, {59'd0, rt_addr_o}, {59'd0, e.rt});
            check({"R11 ra addr ", e.tag}, {59'd0, ra_addr_o}, {59'd0, e.ra});
            check({"R5 R6 R7 rt data ", e.tag}, rt_data_o, e.rt_val);
            check({"R2 R3 R4 ra data ", e.tag}, ra_data_o, e.ra_val);
            check({"R1 mem addr ", e.tag}, last_addr, e.addr);
            check({"R1 mem size ", e.tag}, {62'd0, last_size}, {62'd0, e.size});
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 reset ready", {63'd0, issue_ready_o}, 64'd1);
    check("R10 reset done", {63'd0, done_o}, 64'd0);
    check("R1 reset req", {63'd0, mem_req_valid_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // sizes: 0 B, 1 H, 2 W, 3 D; forms: 0 disp, 1 scaled, 2 index, 3 rsvd
    issue("R2 R5 byte disp+", 2'd0, 1'b0, 2'd0, 5'd4, 5'd3, 16'h0008, 64'h0000_1000_0000_00F3, 64'd0);
    issue("R2 R5 byte disp-", 2'd0, 1'b0, 2'd0, 5'd5, 5'd6, 16'hFFFC, 64'h0000_0000_0000_0081, 64'd0);
    issue("R5 half zero", 2'd1, 1'b0, 2'd0, 5'd7, 5'd8, 16'h0002, 64'h0000_0000_0000_9AB0, 64'd0);
    issue("R6 half sext neg disp", 2'd1, 1'b1, 2'd0, 5'd9, 5'd10, 16'h7FFF, 64'h0000_2000_0000_8002, 64'd0);
    issue("R6 half sext pos idx", 2'd1, 1'b1, 2'd2, 5'd11, 5'd12, 16'd0, 64'h0000_0000_0000_4002, 64'h40);
    issue("R5 word zero disp", 2'd2, 1'b0, 2'd0, 5'd13, 5'd14, 16'h8000, 64'h0000_0001_8765_4320, 64'd0);
    issue("R6 word sext idx neg", 2'd2, 1'b1, 2'd2, 5'd15, 5'd16, 16'd0, 64'h0000_0003_F000_0004, 64'hFFFF_FFFF_FFFF_FFF0);
    issue("R6 word sext idx pos", 2'd2, 1'b1, 2'd2, 5'd17, 5'd18, 16'd0, 64'h0000_0003_1234_5678, 64'h8);
    issue("R3 R7 dbl scaled neg", 2'd3, 1'b0, 2'd1, 5'd19, 5'd20, 16'h3FFE, 64'h0000_0000_C000_0010, 64'd0);
    issue("R3 dbl scaled pos", 2'd3, 1'b0, 2'd1, 5'd21, 5'd22, 16'h1005, 64'h0000_0044_0000_0100, 64'd0);
    issue("R7 dbl idx sext ignored", 2'd3, 1'b1, 2'd2, 5'd23, 5'd24, 16'd0, 64'h1234_0000_8000_0008, 64'h18);
    issue("R4 idx wrap", 2'd0, 1'b0, 2'd2, 5'd25, 5'd26, 16'd0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20);
    issue("R8 ra zero", 2'd1, 1'b0, 2'd0, 5'd2, 5'd0, 16'h0004, 64'h100, 64'd0);
    issue("R8 ra eq rt", 2'd2, 1'b0, 2'd2, 5'd9, 5'd9, 16'd0, 64'h200, 64'h4);
    issue("R9 sext byte disp", 2'd0, 1'b1, 2'd0, 5'd1, 5'd2, 16'h0001, 64'h300, 64'd0);
    issue("R9 sext byte idx", 2'd0, 1'b1, 2'd2, 5'd1, 5'd2, 16'd0, 64'h300, 64'h1);
    issue("R9 sext word disp", 2'd2, 1'b1, 2'd0, 5'd1, 5'd2, 16'h0004, 64'h400, 64'd0);
    issue("R9 scaled half", 2'd1, 1'b0, 2'd1, 5'd1, 5'd2, 16'h0004, 64'h500, 64'd0);
    issue("R9 disp dbl", 2'd3, 1'b0, 2'd0, 5'd1, 5'd2, 16'h0008, 64'h600, 64'd0);
    issue("R9 rsvd form", 2'd1, 1'b0, 2'd3, 5'd1, 5'd2, 16'h0008, 64'h700, 64'd0);
    issue("R2 after invalids", 2'd1, 1'b0, 2'd0, 5'd30, 5'd31, 16'h0010, 64'h0000_0000_0000_7FFE, 64'd0);
    while (sb.size() != 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    check("R8 R1 request count", 64'(seen_reqs), 64'(exp_reqs));
    check("R10 idle at end", {63'd0, issue_ready_o}, 64'd1);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule